// File: doc/BRIEF.md
# Banked Data Memory Front End

This block is the byte-wide data memory seen by a small 8-bit processor core. It takes a 6-bit register address on a read port and on a separate write port. It resolves each address to one of several places: a pointer register, a bank register, a common general-register region, a banked general-register window, or nothing at all. Address 0x00 holds no storage. An access there is redirected to the data address held in the pointer register. This lets the core walk through memory without encoding the address in the instruction.

The upper half of the address space (0x20 to 0x3F) is a 32-byte window. Four separate copies of it exist, and a 2-bit bank number selects which one is used. The same bank number leaves the block on a dedicated output, so that the neighbouring control-register file can use it to select its own bank. Reads are combinational from the address, the pointer and the current bank. Writes take effect on the rising clock edge.

Top module: `dmem_banked`

## Requirements
- R1: After synchronous reset, the pointer register and the bank register both read 0x00, and `bank_sel` is 0.
- R2: A write to address 0x01 stores bits 1:0 of the data as the bank number. `bank_sel` shows the new value from the clock edge of that write onward.
- R3: A read of address 0x01 returns the bank number in bits 1:0 and zero in bits 7:2, whatever was written to those bits.
- R4: Address 0x04 is the pointer register. All 8 bits are written and read back unchanged.
- R5: A read of address 0x00 returns the contents of the data address given by pointer bits 5:0. Pointer bits 7:6 are ignored.
- R6: A write to address 0x00 lands at the data address given by pointer bits 5:0. This includes the bank register and the pointer register itself.
- R7: When pointer bits 5:0 are zero, a read of 0x00 returns 0x00, and a write to 0x00 changes neither the pointer, the bank register nor any general register.
- R8: Addresses 0x05 to 0x1F form one common region. A value written there reads back the same under every bank number.
- R9: Addresses 0x20 to 0x3F are banked. Each of the four bank numbers has its own 32 bytes, and a write under one bank does not alter the others.
- R10: Addresses 0x02 and 0x03 belong to other units. They read as 0x00 here, and writes to them are ignored.
- R11: A read reflects a write to the same location only after the rising clock edge that performs the write. Before that edge it returns the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rd_addr | input | 6 | Read address |
| rd_data | output | 8 | Read data, combinational from address, pointer and bank |
| wr_addr | input | 6 | Write address |
| wr_data | input | 8 | Write data |
| wr_en | input | 1 | Write enable, sampled on the rising edge |
| bank_sel | output | 2 | Current bank number for the control-register space |

## Verification
Read data is due in the same cycle as the read address, because the read path has no register. The bench therefore changes `rd_addr` on the falling edge and samples `rd_data` one time unit later, before the next rising edge.

A write, including a redirected one, changes state only at the rising edge that follows the falling edge on which it was driven. For this reason every readback and every `bank_sel` check is taken after that edge. One check reads the target location in the same half-cycle as the pending write, to confirm that the old value is still visible before the edge.

The bench keeps its own model of the pointer, the bank number and all storage. It compares each result against that model.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

  typedef enum logic [2:0] {
    RGN_NULL,
    RGN_BANKREG,
    RGN_PTRREG,
    RGN_FOREIGN,
    RGN_COMMON,
    RGN_BANKED
  } region_e;

endpackage

// File: rtl/dmem_decode.sv
module dmem_decode
  import dmem_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] ptr_lo,
  output region_e           region,
  output logic [ADDR_W-2:0] offset
);
  localparam logic [ADDR_W-1:0] A_INDIR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_BANK  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_FOR0  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_FOR1  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_PTR   = ADDR_W'(4);

  logic [ADDR_W-1:0] eff;

  always_comb begin
    eff = (addr == A_INDIR) ? ptr_lo : addr;
    offset = eff[ADDR_W-2:0];
    if (eff == A_INDIR)                       region = RGN_NULL;
    else if (eff == A_BANK)                   region = RGN_BANKREG;
    else if (eff == A_FOR0 || eff == A_FOR1)  region = RGN_FOREIGN;
    else if (eff == A_PTR)                    region = RGN_PTRREG;
    else if (eff[ADDR_W-1])                   region = RGN_BANKED;
    else                                      region = RGN_COMMON;
  end
endmodule

// File: rtl/dmem_ctrl_regs.sv
module dmem_ctrl_regs
  import dmem_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  region_e           wr_region,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] ptr_q,
  output logic [BANK_W-1:0] bank_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q  <= '0;
      bank_q <= '0;
    end else if (wr_en) begin
      if (wr_region == RGN_PTRREG)  ptr_q  <= wr_data;
      if (wr_region == RGN_BANKREG) bank_q <= wr_data[BANK_W-1:0];
    end
  end

  // R1: reset leaves both control registers cleared
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (ptr_q == '0 && bank_q == '0));

  // R7: a write that resolves to nothing leaves the registers untouched
  assert_null_write_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_region == RGN_NULL) |=> ($stable(ptr_q) && $stable(bank_q)));
endmodule

// File: rtl/dmem_store.sv
module dmem_store
  import dmem_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic [BANK_W-1:0] bank,
  input  logic              wr_en,
  input  region_e           wr_region,
  input  logic [ADDR_W-2:0] wr_offset,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-2:0] rd_offset,
  output logic [DATA_W-1:0] common_rd,
  output logic [DATA_W-1:0] banked_rd
);
  localparam int WIN_N   = 1 << (ADDR_W - 1);
  localparam int BANKS_N = 1 << BANK_W;
  localparam int IDX_W   = BANK_W + ADDR_W - 1;

  logic [DATA_W-1:0] common_mem [WIN_N];
  logic [DATA_W-1:0] banked_mem [BANKS_N * WIN_N];

  logic [IDX_W-1:0] wr_idx, rd_idx;
  assign wr_idx = {bank, wr_offset};
  assign rd_idx = {bank, rd_offset};

  always_ff @(posedge clk) begin
    if (wr_en && wr_region == RGN_COMMON) common_mem[wr_offset] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (wr_en && wr_region == RGN_BANKED) banked_mem[wr_idx] <= wr_data;
  end

  assign common_rd = common_mem[rd_offset];
  assign banked_rd = banked_mem[rd_idx];
endmodule

// File: rtl/dmem_banked.sv
module dmem_banked
  import dmem_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_en,
  output logic [BANK_W-1:0] bank_sel
);
  localparam int OFF_W = ADDR_W - 1;

  logic [DATA_W-1:0] ptr_q;
  logic [BANK_W-1:0] bank_q;
  region_e           rd_region, wr_region;
  logic [OFF_W-1:0]  rd_offset, wr_offset;
  logic [DATA_W-1:0] common_rd, banked_rd;

  dmem_decode #(.ADDR_W(ADDR_W)) u_rd_dec (
    .addr(rd_addr), .ptr_lo(ptr_q[ADDR_W-1:0]),
    .region(rd_region), .offset(rd_offset)
  );

  dmem_decode #(.ADDR_W(ADDR_W)) u_wr_dec (
    .addr(wr_addr), .ptr_lo(ptr_q[ADDR_W-1:0]),
    .region(wr_region), .offset(wr_offset)
  );

  dmem_ctrl_regs #(.DATA_W(DATA_W), .BANK_W(BANK_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_region(wr_region),
    .wr_data(wr_data), .ptr_q(ptr_q), .bank_q(bank_q)
  );

  dmem_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_store (
    .clk(clk), .bank(bank_q), .wr_en(wr_en), .wr_region(wr_region),
    .wr_offset(wr_offset), .wr_data(wr_data), .rd_offset(rd_offset),
    .common_rd(common_rd), .banked_rd(banked_rd)
  );

  always_comb begin
    case (rd_region)
      RGN_BANKREG: rd_data = {{(DATA_W-BANK_W){1'b0}}, bank_q};
      RGN_PTRREG:  rd_data = ptr_q;
      RGN_COMMON:  rd_data = common_rd;
      RGN_BANKED:  rd_data = banked_rd;
      default:     rd_data = '0;
    endcase
  end

  assign bank_sel = bank_q;

  // R2: a direct bank write shows on bank_sel after its edge
  assert_bank_out_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_W'(1)) |=> (bank_sel == $past(wr_data[BANK_W-1:0])));

  // R3: unused bank bits read as zero
  assert_bank_hi_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == ADDR_W'(1)) |-> (rd_data[DATA_W-1:BANK_W] == '0));

  // R4: direct pointer write stores all bits
  assert_ptr_write_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_W'(4)) |=> (ptr_q == $past(wr_data)));

  // R7: indirect read through a zero pointer yields zero
  assert_null_read_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == '0 && ptr_q[ADDR_W-1:0] == '0) |-> (rd_data == '0));

  // R10: foreign addresses read as zero
  assert_foreign_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == ADDR_W'(2) || rd_addr == ADDR_W'(3)) |-> (rd_data == '0));
endmodule

// File: tb/test_dmem_banked.sv
module test_dmem_banked;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [5:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       wr_en = 1'b0;
  logic [1:0] bank_sel;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [7:0] m_common [32];
  logic [7:0] m_banked [4][32];
  logic [7:0] m_ptr;
  logic [1:0] m_bank;

  always #(CLK_P/2) clk = ~clk;

  dmem_banked i_dmem_banked (
    .clk(clk), .rst(rst), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_en(wr_en), .bank_sel(bank_sel)
  );

  function automatic logic [7:0] pat(int b, int a);
    return 8'(((a * 37) + (b * 101) + 11) ^ 8'h5A);
  endfunction

  function automatic logic [5:0] resolve(logic [5:0] a);
    return (a == 6'd0) ? m_ptr[5:0] : a;
  endfunction

  function automatic logic [7:0] exp_read(logic [5:0] a);
    logic [5:0] e;
    e = resolve(a);
    if (e == 6'd0 || e == 6'd2 || e == 6'd3) return 8'h00;
    if (e == 6'd1) return {6'b0, m_bank};
    if (e == 6'd4) return m_ptr;
    if (e < 6'd32) return m_common[e[4:0]];
    return m_banked[m_bank][e[4:0]];
  endfunction

  task automatic model_write(logic [5:0] a, logic [7:0] d);
    logic [5:0] e;
    e = resolve(a);
    if (e == 6'd1) m_bank = d[1:0];
    else if (e == 6'd4) m_ptr = d;
    else if (e >= 6'd5 && e < 6'd32) m_common[e[4:0]] = d;
    else if (e >= 6'd32) m_banked[m_bank][e[4:0]] = d;
  endtask

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [7:0] d);
    @(negedge clk);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
  endtask

  task automatic rd_chk(string req, logic [5:0] a);
    rd_addr = a;
    #1;
    chk(req, rd_data, exp_read(a));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    m_ptr = 8'h00; m_bank = 2'd0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset values
    rd_addr = 6'd4; #1; chk("R1 ptr", rd_data, 8'h00);
    rd_addr = 6'd1; #1; chk("R1 bank", rd_data, 8'h00);
    chk("R1 bank_sel", {6'b0, bank_sel}, 8'h00);

    // Fill all banks (R2, R9) and the common region (R8)
    for (int b = 0; b < 4; b++) begin
      wr(6'd1, {6'(8'h3F ^ (b * 5)), 2'(b)});
      #1; chk("R2 bank_sel", {6'b0, bank_sel}, 8'(b));
      rd_chk("R3 bank readback", 6'd1);
      for (int a = 32; a < 64; a++) wr(6'(a), pat(b, a));
    end
    for (int a = 5; a < 32; a++) wr(6'(a), pat(7, a));

    // R10: foreign addresses ignore writes
    wr(6'd2, 8'hFF); wr(6'd3, 8'hA5);

    // Direct sweep under every bank (R8, R9, R10, R3)
    for (int b = 0; b < 4; b++) begin
      wr(6'd1, 8'(b) | 8'hFC);
      for (int a = 1; a < 64; a++) begin
        if (a == 2 || a == 3) rd_chk("R10 foreign", 6'(a));
        else if (a == 1) rd_chk("R3 bank bits", 6'(a));
        else if (a < 32) rd_chk("R8 common", 6'(a));
        else rd_chk("R9 banked", 6'(a));
      end
    end

    // R4, R5, R7: pointer over all values, indirect read
    for (int p = 0; p < 256; p++) begin
      wr(6'd4, 8'(p));
      rd_chk("R4 ptr readback", 6'd4);
      if (p[5:0] == 0) rd_chk("R7 null read", 6'd0);
      else rd_chk("R5 indirect read", 6'd0);
    end

    // R6: indirect writes into common and banked locations
    for (int a = 5; a < 64; a += 3) begin
      wr(6'd4, 8'(a) | 8'h80);
      wr(6'd0, 8'(a * 3 + 1));
      rd_chk("R6 indirect write", 6'(a));
    end

    // R6: indirect write to the bank register and to the pointer
    wr(6'd4, 8'h01);
    wr(6'd0, 8'hEE);
    #1; chk("R6 bank via ptr", {6'b0, bank_sel}, 8'h02);
    rd_chk("R6 bank readback", 6'd1);
    wr(6'd4, 8'h44);
    wr(6'd0, 8'h27);
    rd_chk("R6 ptr via ptr", 6'd4);
    rd_chk("R6 follow new ptr", 6'd0);

    // R7: write through a zero pointer is ignored
    wr(6'd4, 8'hC0);
    wr(6'd0, 8'h99);
    rd_chk("R7 ptr unchanged", 6'd4);
    rd_chk("R7 bank unchanged", 6'd1);
    rd_chk("R7 null read after", 6'd0);
    for (int a = 5; a < 64; a++) rd_chk("R7 storage unchanged", 6'(a));

    // R11: write not visible before its edge, visible after
    @(negedge clk);
    wr_addr = 6'd10; wr_data = 8'h3C; wr_en = 1'b1; rd_addr = 6'd10;
    #1; chk("R11 before edge", rd_data, m_common[10]);
    @(negedge clk);
    wr_en = 1'b0;
    model_write(6'd10, 8'h3C);
    #1; chk("R11 after edge", rd_data, 8'h3C);

    finish_run();
  end
endmodule